// File: doc/BRIEF.md
# Narrow Bus Bridge

The bridge joins a 32-bit memory-mapped master to a slave port that is only 8 or 16 bits wide. Which of two address-alignment schemes it uses is fixed at elaboration. In the dynamic scheme the master sees the narrow slave as one unbroken byte space. Each 32-bit access is cut into several slave beats, issued lowest first. Read beats are stitched back into a full word. Write beats carry their own byte enables, and a beat whose enables are all clear is never issued. In the native scheme every master access becomes exactly one slave access on the lowest lanes. Successive slave words then sit four master bytes apart.

The master holds its request until its wait-request falls. The fall happens in the cycle in which the final slave beat is accepted. Assembled read data returns one cycle later, marked by a single-cycle valid strobe. The slave may stall any beat with its own wait-request. Slave reads are taken as zero-latency: the data is valid in the cycle the beat is accepted.

Top module: `narrow_bus_bridge`

## Requirements
- R1: In dynamic mode a master read produces NB = 32/SLV_W slave reads, with beat k = 0..NB-1 issued in ascending order at slave address (m_addr >> 2) * NB + k. The low two bits of m_addr never affect the slave address.
- R2: In dynamic mode the returned read word holds the data of beat k in bits [k*SLV_W +: SLV_W].
- R3: In native mode each master read or write produces exactly one slave transfer at slave address m_addr >> 2. That transfer carries m_wdata[SLV_W-1:0] and m_be[SLV_W/8-1:0], and it is issued even when those enables are all zero.
- R4: In native mode the returned read word carries the slave data in bits [SLV_W-1:0], and every bit above those is zero.
- R5: In dynamic mode write beat k carries m_wdata[k*SLV_W +: SLV_W] on s_wdata and m_be[k*SLV_W/8 +: SLV_W/8] on s_be.
- R6: In dynamic mode a write beat whose byte-enable slice is zero is not issued. A write with m_be = 0 completes in its first cycle with m_waitreq low and no slave strobe.
- R7: While a request is present, m_waitreq is high in every cycle except the one in which the last slave beat is accepted (s_waitreq low) or no beat is needed. With no request it is low.
- R8: m_rvalid is high for exactly the one cycle after a master read completes, and at no other time.
- R9: A beat stalled by s_waitreq is presented again unchanged in the next cycle. No beat is lost, repeated after acceptance or reordered.
- R10: During and directly after the active-high synchronous reset, with no request, m_waitreq, m_rvalid, s_read and s_write are all low.
- R11: s_read and s_write are never high together, and s_read is only high while m_read is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_addr | input | ADDR_W | Master byte address |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_wdata | input | 32 | Master write data |
| m_be | input | 4 | Master byte enables |
| m_waitreq | output | 1 | Stall toward the master |
| m_rdata | output | 32 | Assembled read data |
| m_rvalid | output | 1 | Read data valid, one cycle |
| s_addr | output | S_AW | Slave word address |
| s_read | output | 1 | Slave read strobe |
| s_write | output | 1 | Slave write strobe |
| s_wdata | output | SLV_W | Slave write data |
| s_be | output | SLV_W/8 | Slave byte enables |
| s_rdata | input | SLV_W | Slave read data, valid when the beat is accepted |
| s_waitreq | input | 1 | Stall from the slave |

## Verification
The bench builds four copies of the bridge with ADDR_W = 8: dynamic with an 8-bit slave, dynamic with a 16-bit slave, native with a 16-bit slave and native with an 8-bit slave. Four-beat splitting with three active beat indices is only reachable with the 8-bit dynamic copy. The two-beat case, where a zero upper or lower enable half removes a beat, needs the 16-bit dynamic copy. The native copies put the zero upper read lanes and the zero-enable single write within reach. Random slave stalls on every copy exercise beat holding at each beat position.

// File: rtl/nbw_pkg.sv
package nbw_pkg;

    localparam int MST_W  = 32;
    localparam int MST_BE = MST_W / 8;

    typedef enum logic {
        ALIGN_NATIVE  = 1'b0,
        ALIGN_DYNAMIC = 1'b1
    } align_e;

    // master request as seen by the bridge
    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [MST_W-1:0]  wdata;
        logic [MST_BE-1:0] be;
    } mreq_t;

    // read response toward the master
    typedef struct packed {
        logic             valid;
        logic [MST_W-1:0] data;
    } mrsp_t;

    function automatic int beats_for(align_e mode, int slv_w);
        return (mode == ALIGN_DYNAMIC) ? (MST_W / slv_w) : 1;
    endfunction

    function automatic int idx_width(int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/nbw_beat_pick.sv
module nbw_beat_pick #(
    parameter int NB = 4,
    parameter int CW = 2
) (
    input  logic [NB-1:0] en,
    input  logic [CW-1:0] start,
    output logic          found,
    output logic [CW-1:0] cur,
    output logic          last
);
    // first enabled beat at or above start; last when none follows it
    always_comb begin
        found = 1'b0;
        cur   = start;
        last  = 1'b1;
        for (int k = 0; k < NB; k++) begin
            if (!found && (k >= int'(start)) && en[k]) begin
                found = 1'b1;
                cur   = CW'(k);
            end else if (found && en[k]) begin
                last = 1'b0;
            end
        end
    end
endmodule

// File: rtl/nbw_lane_steer.sv
module nbw_lane_steer
    import nbw_pkg::*;
#(
    parameter int SLV_W = 8,
    parameter int NB    = 4,
    parameter int CW    = 2
) (
    input  logic [MST_W-1:0]     wdata,
    input  logic [MST_BE-1:0]    be,
    input  logic                 skip_zero,
    input  logic [CW-1:0]        cur,
    output logic [NB-1:0]        en,
    output logic [SLV_W-1:0]     s_wdata,
    output logic [SLV_W/8-1:0]   s_be
);
    localparam int SBE = SLV_W / 8;

    for (genvar k = 0; k < NB; k++) begin : g_en
        assign en[k] = !skip_zero || (be[k*SBE +: SBE] != '0);
    end

    assign s_wdata = wdata[cur*SLV_W +: SLV_W];
    assign s_be    = be[cur*SBE +: SBE];
endmodule

// File: rtl/nbw_read_merge.sv
module nbw_read_merge
    import nbw_pkg::*;
#(
    parameter int SLV_W = 8,
    parameter int NB    = 4,
    parameter int CW    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             finish,
    input  logic [CW-1:0]    cur,
    input  logic [SLV_W-1:0] s_rdata,
    output mrsp_t            rsp
);
    logic [NB-1:0][SLV_W-1:0] lanes;
    logic [MST_W-1:0]         merged;

    // the final beat bypasses the lane store
    always_comb begin
        merged = '0;
        for (int k = 0; k < NB; k++) begin
            merged[k*SLV_W +: SLV_W] = (CW'(k) == cur) ? s_rdata : lanes[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lanes <= '0;
            rsp   <= '0;
        end else begin
            if (capture) lanes[cur] <= s_rdata;
            rsp.valid <= finish;
            if (finish) rsp.data <= merged;
        end
    end
endmodule

// File: rtl/narrow_bus_bridge.sv
module narrow_bus_bridge
    import nbw_pkg::*;
#(
    parameter align_e ALIGN  = ALIGN_DYNAMIC,
    parameter int     SLV_W  = 8,
    parameter int     ADDR_W = 12,
    localparam int    NB     = beats_for(ALIGN, SLV_W),
    localparam int    BB     = $clog2(NB),
    localparam int    S_AW   = ADDR_W - 2 + BB
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    m_addr,
    input  logic                 m_read,
    input  logic                 m_write,
    input  logic [MST_W-1:0]     m_wdata,
    input  logic [MST_BE-1:0]    m_be,
    output logic                 m_waitreq,
    output logic [MST_W-1:0]     m_rdata,
    output logic                 m_rvalid,
    output logic [S_AW-1:0]      s_addr,
    output logic                 s_read,
    output logic                 s_write,
    output logic [SLV_W-1:0]     s_wdata,
    output logic [SLV_W/8-1:0]   s_be,
    input  logic [SLV_W-1:0]     s_rdata,
    input  logic                 s_waitreq
);
    localparam int CW = idx_width(NB);

    mreq_t             req;
    mrsp_t             rsp;
    logic              active;
    logic [NB-1:0]     en;
    logic [CW-1:0]     next_q;
    logic [CW-1:0]     cur;
    logic              found;
    logic              last;
    logic              issue;
    logic              beat_done;
    logic              finish;
    logic [ADDR_W-1:0] word_idx;

    assign req    = '{rd: m_read, wr: m_write, wdata: m_wdata, be: m_be};
    assign active = req.rd | req.wr;

    nbw_lane_steer #(.SLV_W(SLV_W), .NB(NB), .CW(CW)) u_steer (
        .wdata     (req.wdata),
        .be        (req.be),
        .skip_zero ((ALIGN == ALIGN_DYNAMIC) && req.wr),
        .cur       (cur),
        .en        (en),
        .s_wdata   (s_wdata),
        .s_be      (s_be)
    );

    nbw_beat_pick #(.NB(NB), .CW(CW)) u_pick (
        .en    (en),
        .start (next_q),
        .found (found),
        .cur   (cur),
        .last  (last)
    );

    assign issue     = active & found;
    assign beat_done = issue & !s_waitreq;
    assign finish    = beat_done & last;

    assign m_waitreq = issue & !finish;
    assign s_read    = issue & req.rd;
    assign s_write   = issue & req.wr & !req.rd;

    assign word_idx = m_addr >> 2;
    assign s_addr   = S_AW'(word_idx) * S_AW'(NB) + S_AW'(cur);

    // beat sequencer: start index of the next search
    always_ff @(posedge clk) begin
        if (rst) begin
            next_q <= '0;
        end else if (finish || (active && !found)) begin
            next_q <= '0;
        end else if (beat_done) begin
            next_q <= cur + CW'(1);
        end
    end

    nbw_read_merge #(.SLV_W(SLV_W), .NB(NB), .CW(CW)) u_merge (
        .clk     (clk),
        .rst     (rst),
        .capture (beat_done & req.rd),
        .finish  (finish & req.rd),
        .cur     (cur),
        .s_rdata (s_rdata),
        .rsp     (rsp)
    );

    assign m_rdata  = rsp.data;
    assign m_rvalid = rsp.valid;
endmodule

// File: rtl/nbw_checker.sv
module nbw_checker
    import nbw_pkg::*;
#(
    parameter align_e ALIGN  = ALIGN_DYNAMIC,
    parameter int     SLV_W  = 8,
    parameter int     ADDR_W = 12,
    localparam int    NB     = beats_for(ALIGN, SLV_W),
    localparam int    BB     = $clog2(NB),
    localparam int    S_AW   = ADDR_W - 2 + BB
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  m_addr,
    input logic               m_read,
    input logic               m_write,
    input logic               m_waitreq,
    input logic [MST_W-1:0]   m_rdata,
    input logic               m_rvalid,
    input logic [S_AW-1:0]    s_addr,
    input logic               s_read,
    input logic               s_write,
    input logic [SLV_W/8-1:0] s_be,
    input logic               s_waitreq
);
    p_excl_strobes_r11: assert property (@(posedge clk) disable iff (rst)
        !(s_read && s_write));

    p_read_needs_master_r11: assert property (@(posedge clk) disable iff (rst)
        s_read |-> m_read);

    p_wait_needs_req_r7: assert property (@(posedge clk) disable iff (rst)
        m_waitreq |-> (m_read || m_write));

    p_stall_holds_beat_r9: assert property (@(posedge clk) disable iff (rst)
        ((s_read || s_write) && s_waitreq) |=> ((s_read || s_write) && $stable(s_addr)));

    p_rvalid_after_read_r8: assert property (@(posedge clk) disable iff (rst)
        m_rvalid |-> $past(m_read && !m_waitreq));

    p_rdata_known_r2: assert property (@(posedge clk) disable iff (rst)
        m_rvalid |-> !$isunknown(m_rdata));

    // beat address lies inside the master word (R1, R3)
    p_addr_in_word_r3: assert property (@(posedge clk) disable iff (rst)
        (s_read || s_write) |-> ((s_addr >> BB) == S_AW'(m_addr >> 2)));

    p_native_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        ((ALIGN == ALIGN_NATIVE) && m_rvalid) |-> ((m_rdata >> SLV_W) == '0));

    p_dyn_no_empty_write_r6: assert property (@(posedge clk) disable iff (rst)
        ((ALIGN == ALIGN_DYNAMIC) && s_write) |-> (s_be != '0));
endmodule

bind narrow_bus_bridge nbw_checker #(.ALIGN(ALIGN), .SLV_W(SLV_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .m_addr    (m_addr),
    .m_read    (m_read),
    .m_write   (m_write),
    .m_waitreq (m_waitreq),
    .m_rdata   (m_rdata),
    .m_rvalid  (m_rvalid),
    .s_addr    (s_addr),
    .s_read    (s_read),
    .s_write   (s_write),
    .s_be      (s_be),
    .s_waitreq (s_waitreq)
);

// File: tb/nb_harness.sv
module nb_harness
    import nbw_pkg::*;
#(
    parameter align_e ALIGN = ALIGN_DYNAMIC,
    parameter int     SLV_W = 8,
    parameter int     ID    = 0
) (
    input  logic clk,
    input  logic rst,
    output logic done,
    output int   n_run,
    output int   n_fail
);
    localparam int  AW   = 8;
    localparam bit  DYN  = (ALIGN == ALIGN_DYNAMIC);
    localparam int  SBE  = SLV_W / 8;
    localparam int  NB   = DYN ? (32 / SLV_W) : 1;
    localparam int  BB   = $clog2(NB);
    localparam int  S_AW = AW - 2 + BB;
    localparam int  DEPTH = 1 << S_AW;

    logic [AW-1:0]    m_addr;
    logic             m_read, m_write, m_waitreq, m_rvalid;
    logic [31:0]      m_wdata, m_rdata;
    logic [3:0]       m_be;
    logic [S_AW-1:0]  s_addr;
    logic             s_read, s_write, s_waitreq;
    logic [SLV_W-1:0] s_wdata, s_rdata;
    logic [SBE-1:0]   s_be;

    logic [SLV_W-1:0] mem [DEPTH];

    narrow_bus_bridge #(.ALIGN(ALIGN), .SLV_W(SLV_W), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst),
        .m_addr(m_addr), .m_read(m_read), .m_write(m_write),
        .m_wdata(m_wdata), .m_be(m_be), .m_waitreq(m_waitreq),
        .m_rdata(m_rdata), .m_rvalid(m_rvalid),
        .s_addr(s_addr), .s_read(s_read), .s_write(s_write),
        .s_wdata(s_wdata), .s_be(s_be), .s_rdata(s_rdata), .s_waitreq(s_waitreq)
    );

    assign s_rdata = mem[s_addr];

    typedef struct {
        bit wr;
        int addr;
        int data;
        int be;
    } beat_t;

    beat_t       bq[$];
    logic [31:0] rq[$];
    bit          rv_exp;
    bit          fin;
    int          stalls;
    bit          req, acc, ew;
    beat_t       e;

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cfg%0d t=%0t act=%h exp=%h", r, ID, $time, act, exp);
        end
    endtask

    always @(negedge clk) s_waitreq <= ($urandom_range(0, 99) < 35);

    // per-cycle reference model
    always @(negedge clk) begin
        #1;
        fin = 0;
        if (rst) begin
            rv_exp = 0;
        end else begin
            req = m_read || m_write;
            acc = s_read || s_write;
            chk(!(s_read && s_write) && !(s_read && !m_read), "R11", {s_read, s_write}, {1'b0, m_read});
            chk(acc == (req && bq.size() > 0), DYN ? "R6" : "R3", 32'(acc), 32'(req && bq.size() > 0));
            if (acc && bq.size() > 0) begin
                e = bq[0];
                chk(s_write == e.wr, "R11", 32'(s_write), 32'(e.wr));
                chk(int'(s_addr) == e.addr, DYN ? "R1" : "R3", 32'(s_addr), e.addr);
                if (e.wr) begin
                    chk(int'(s_wdata) == e.data, DYN ? "R5" : "R3", 32'(s_wdata), e.data);
                    chk(int'(s_be) == e.be, DYN ? "R5" : "R3", 32'(s_be), e.be);
                end
            end
            ew = req && bq.size() > 0 && !(!s_waitreq && bq.size() == 1);
            chk(m_waitreq == ew, "R7", 32'(m_waitreq), 32'(ew));
            chk(m_rvalid == rv_exp, "R8", 32'(m_rvalid), 32'(rv_exp));
            if (m_rvalid && rv_exp && rq.size() > 0) begin
                logic [31:0] x;
                x = rq.pop_front();
                chk(m_rdata == x, DYN ? "R2" : "R4", m_rdata, x);
            end
            if (req && bq.size() > 0) begin
                if (s_waitreq) stalls++;
                else begin
                    e = bq.pop_front();
                    if (e.wr)
                        for (int b = 0; b < SBE; b++)
                            if (e.be[b]) mem[e.addr][b*8 +: 8] = 8'(e.data >> (8*b));
                end
            end
            rv_exp = m_read && req && !ew;
            fin = req && !ew;
        end
    end

    task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] rexp;
        rexp = '0;
        for (int k = 0; k < NB; k++) begin
            int sa;
            int sl;
            sa = int'(a >> 2) * NB + k;
            sl = int'(be[k*SBE +: SBE]);
            if (!(wr && DYN && sl == 0)) begin
                bq.push_back('{wr: wr, addr: sa, data: int'(d[k*SLV_W +: SLV_W]), be: sl});
                if (!wr) rexp[k*SLV_W +: SLV_W] = mem[sa];
            end
        end
        if (!wr) rq.push_back(rexp);
        m_addr = a; m_wdata = d; m_be = be;
        m_read = !wr; m_write = wr;
        do @(posedge clk); while (!fin);
        @(negedge clk);
        m_read = 0; m_write = 0;
    endtask

    initial begin
        done = 0; n_run = 0; n_fail = 0; stalls = 0;
        m_addr = '0; m_read = 0; m_write = 0; m_wdata = '0; m_be = '0;
        for (int i = 0; i < DEPTH; i++) mem[i] = SLV_W'(i * 37 + ID * 11 + 5);
        repeat (2) @(negedge clk);
        #1;
        // R10: idle outputs while reset is held
        chk(!m_waitreq && !m_rvalid && !s_read && !s_write, "R10",
            {m_waitreq, m_rvalid, s_read, s_write}, 32'h0);
        while (rst) @(negedge clk);
        #1;
        chk(!m_waitreq && !m_rvalid && !s_read && !s_write, "R10",
            {m_waitreq, m_rvalid, s_read, s_write}, 32'h0);
        @(negedge clk);
        xfer(1, 8'h10, 32'h1234_5678, 4'hF);
        xfer(0, 8'h10, '0, 4'hF);
        xfer(1, 8'h10, 32'hDEAD_BEEF, 4'h0);  // R6 empty write
        xfer(0, 8'h13, '0, 4'hF);             // R1 low bits ignored
        xfer(1, 8'h10, 32'hAABB_CCDD, 4'b0100);
        xfer(1, 8'h14, 32'h0102_0304, 4'b1001);
        xfer(0, 8'h10, '0, 4'hF);
        xfer(0, 8'h14, '0, 4'hF);
        for (int n = 0; n < 250; n++) begin
            logic [3:0] be;
            be = ($urandom_range(0, 7) == 0) ? 4'h0 : 4'($urandom);
            if ($urandom_range(0, 3) == 0) @(negedge clk);
            xfer(bit'($urandom_range(0, 1)), AW'($urandom), $urandom, be);
        end
        repeat (3) @(negedge clk);
        chk(stalls > 0, "R9", stalls, 1);
        chk(bq.size() == 0 && rq.size() == 0, "R9", bq.size() + rq.size(), 0);
        done = 1;
    end
endmodule

// File: tb/tb_narrow_bus_bridge.sv
module tb_narrow_bus_bridge;
    import nbw_pkg::*;

    logic clk = 1'b0;
    logic rst;
    always #2 clk = ~clk;

    logic d0, d1, d2, d3;
    int   r0, r1, r2, r3, f0, f1, f2, f3;

    nb_harness #(.ALIGN(ALIGN_DYNAMIC), .SLV_W(8),  .ID(0)) h_dyn8  (.clk(clk), .rst(rst), .done(d0), .n_run(r0), .n_fail(f0));
    nb_harness #(.ALIGN(ALIGN_DYNAMIC), .SLV_W(16), .ID(1)) h_dyn16 (.clk(clk), .rst(rst), .done(d1), .n_run(r1), .n_fail(f1));
    nb_harness #(.ALIGN(ALIGN_NATIVE),  .SLV_W(16), .ID(2)) h_nat16 (.clk(clk), .rst(rst), .done(d2), .n_run(r2), .n_fail(f2));
    nb_harness #(.ALIGN(ALIGN_NATIVE),  .SLV_W(8),  .ID(3)) h_nat8  (.clk(clk), .rst(rst), .done(d3), .n_run(r3), .n_fail(f3));

    initial begin
        int cyc;
        int wd;
        cyc = 0;
        wd  = 0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        while (!(d0 && d1 && d2 && d3) && cyc < 100000) begin
            @(negedge clk);
            cyc++;
        end
        if (!(d0 && d1 && d2 && d3)) begin
            wd = 1;
            $display("FAIL R7 watchdog act=timeout exp=all transfers complete");
        end
        $display("[TB] %0d tests run, %0d failed", r0 + r1 + r2 + r3 + wd, f0 + f1 + f2 + f3 + wd);
        $finish;
    end
endmodule